// File: doc/BRIEF.md
# Packet Error Rate Meter

This block measures how many received packets arrive damaged over a window of known length. The receive path gives it one strobe per packet and a second strobe that marks that packet as damaged. Software starts a measurement by writing a window length, counted in large units of packets, to a control register. It polls a status flag until the window has run out, then reads the number of damaged packets from three byte-wide result registers.

Writing zero to the control register abandons any measurement and clears all results. Writing a nonzero length starts a fresh window at once, even if one is already running. A measurement only makes progress while the link is up. The block samples the link state, reports it in the status register and drives it onto an active-low indicator output.

Top module: `per_meter`

## Requirements
- R1: After reset, the control register (address 0), the three result bytes (addresses 1, 2, 3) and the status register (address 4) all read 0, and `link_led_n` is 1.
- R2: A write of 0x00 to address 0 clears the error count, the window progress and the done flag. Address 0 then reads 0.
- R3: A write of a nonzero value N to address 0 starts a window of N × 2^UNIT_LOG2 accepted packets (by default N × 65536). The window completes on exactly the last of those packets and not before. Address 0 reads back N.
- R4: Status bit 0 (address 4) reads 1 only once the window has completed. It reads 0 while the window is still in progress.
- R5: Each accepted packet whose `pkt_err` is 1 adds one to the error count. `pkt_err` without `pkt_valid` has no effect. Damaged packets also count toward the window length.
- R6: The error count is 24 bits. Address 1 holds bits [7:0], address 2 holds bits [15:8] and address 3 holds bits [23:16].
- R7: The error count saturates at its all-ones value instead of wrapping.
- R8: Once the window has completed, further packet strobes change neither the count nor the done flag until the next write to address 0.
- R9: A nonzero write while a window is running restarts progress and the error count from zero, using the new length.
- R10: `link_up` is registered once. The registered value appears as status bit 1 and, inverted, on `link_led_n`. Packets are not accepted while the registered link is down.
- R11: A packet strobe in the same cycle as a write to address 0 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| link_up | input | 1 | Link established indication |
| pkt_valid | input | 1 | One-cycle strobe: a packet was received |
| pkt_err | input | 1 | Qualifies `pkt_valid`: the packet was damaged |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational from `rd_addr`) |
| link_led_n | output | 1 | Active-low link indicator |

## Verification
The hardest case to reach from the ports is saturation of the error count. With 24 bits it would take more than sixteen million damaged packets. The bench therefore builds the meter with a narrower count and a short unit length. It then drives a long window made entirely of damaged packets, which pushes the count well past its all-ones value before the window ends. The same run also fills the second result byte, so the byte split of the count is checked as well.

A second case needs a control write and a packet strobe in the same cycle. The bench follows it with a window whose completion cycle shows whether that packet was counted.

// File: rtl/per_pkg.sv
package per_pkg;
  localparam int ADDR_W = 3;
  localparam int REG_W  = 8;
  localparam int RES_W  = 24;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_ERR0 = 3'd1;
  localparam logic [ADDR_W-1:0] A_ERR1 = 3'd2;
  localparam logic [ADDR_W-1:0] A_ERR2 = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_RUN  = 2'd1,
    WIN_DONE = 2'd2
  } win_state_e;
endpackage

// File: rtl/per_window.sv
module per_window
  import per_pkg::*;
#(
  parameter int UNIT_LOG2 = 16,
  parameter int LEN_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             start,
  input  logic [LEN_W-1:0] len_in,
  input  logic             pkt_in,
  output logic             running,
  output logic             done,
  output logic [LEN_W-1:0] len_q
);
  localparam int CNT_W = LEN_W + UNIT_LOG2;

  win_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, target;
  logic [LEN_W-1:0] len_d;

  assign target  = {len_q, {UNIT_LOG2{1'b0}}};
  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    if (clear) begin
      state_d = WIN_IDLE;
      cnt_d   = '0;
      len_d   = '0;
    end else if (start) begin
      state_d = WIN_RUN;
      cnt_d   = '0;
      len_d   = len_in;
    end else if (state_q == WIN_RUN && pkt_in) begin
      cnt_d = cnt_inc;
      if (cnt_inc == target) state_d = WIN_DONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
    end
  end

  assign running = (state_q == WIN_RUN);
  assign done    = (state_q == WIN_DONE);

  // R3: a running window never holds the full count; a finished one holds exactly it
  assert_run_below_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WIN_RUN) |-> (cnt_q < target));
  assert_done_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WIN_DONE) |-> (cnt_q == target));
  // R8: a finished window stays finished and frozen until software writes
  assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WIN_DONE && !clear && !start) |=> (state_q == WIN_DONE && $stable(cnt_q)));
endmodule

// File: rtl/per_errcnt.sv
module per_errcnt #(
  parameter int ERR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [ERR_W-1:0] cnt_q
);
  localparam logic [ERR_W-1:0] SAT = {ERR_W{1'b1}};

  logic [ERR_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                     cnt_d = '0;
    else if (inc && cnt_q != SAT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: the all-ones value is sticky until cleared
  assert_err_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == SAT && !clr) |=> (cnt_q == SAT));
  // R5: without a clear the count moves up by at most one per cycle
  assert_err_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/per_readmux.sv
module per_readmux
  import per_pkg::*;
#(
  parameter int ERR_W = 24
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [REG_W-1:0]  len_q,
  input  logic [ERR_W-1:0]  err_cnt,
  input  logic              done,
  input  logic              link_q,
  output logic [REG_W-1:0]  rd_data
);
  localparam int NBYTES = RES_W / REG_W;

  logic [RES_W-1:0] err_ext;
  logic [REG_W-1:0] res_byte [NBYTES];

  always_comb begin
    err_ext = '0;
    err_ext[ERR_W-1:0] = err_cnt;
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign res_byte[i] = err_ext[REG_W*i +: REG_W];
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data = len_q;
      A_ERR0: rd_data = res_byte[0];
      A_ERR1: rd_data = res_byte[1];
      A_ERR2: rd_data = res_byte[2];
      A_STAT: rd_data = {6'd0, link_q, done};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/per_meter.sv
module per_meter
  import per_pkg::*;
#(
  parameter int UNIT_LOG2 = 16,
  parameter int ERR_W     = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic              pkt_valid,
  input  logic              pkt_err,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              link_led_n
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic             link_q;
  logic             ctrl_wr, clear, start, count_en;
  logic             win_run, win_done;
  logic [REG_W-1:0] len_q;
  logic [ERR_W-1:0] err_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) link_q <= 1'b0;
    else            link_q <= link_up;
  end

  assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
  assign clear    = ctrl_wr && (wr_data == '0);
  assign start    = ctrl_wr && (wr_data != '0);
  assign count_en = win_run && link_q && pkt_valid && !ctrl_wr;

  per_window #(.UNIT_LOG2(UNIT_LOG2), .LEN_W(REG_W)) u_window (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .clear   (clear),
    .start   (start),
    .len_in  (wr_data),
    .pkt_in  (count_en),
    .running (win_run),
    .done    (win_done),
    .len_q   (len_q)
  );

  per_errcnt #(.ERR_W(ERR_W)) u_errcnt (
    .clk   (clk),
    .rst_n (rst_n_int),
    .clr   (ctrl_wr),
    .inc   (count_en && pkt_err),
    .cnt_q (err_cnt)
  );

  per_readmux #(.ERR_W(ERR_W)) u_readmux (
    .rd_addr (rd_addr),
    .len_q   (len_q),
    .err_cnt (err_cnt),
    .done    (win_done),
    .link_q  (link_q),
    .rd_data (rd_data)
  );

  assign link_led_n = ~link_q;

  // R2: a zero control write leaves no result and no done flag behind
  assert_clear_empties_R2: assert property (@(posedge clk) disable iff (!rst_n_int)
    clear |=> (!win_done && err_cnt == '0 && len_q == '0));
  // R10: with the link down and no control write the count is frozen
  assert_link_gate_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!link_q && !ctrl_wr) |=> $stable(err_cnt));
  // R11: a packet colliding with a control write leaves the count at zero
  assert_wr_drops_pkt_R11: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ctrl_wr && pkt_valid && pkt_err) |=> (err_cnt == '0));
endmodule

// File: tb/tb_per_meter.sv
module tb_per_meter;
  localparam int UNIT_LOG2 = 3;
  localparam int ERR_W     = 10;

  logic       clk = 1'b0;
  logic       rst_n, link_up, pkt_valid, pkt_err, wr_en;
  logic [2:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       link_led_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [2:0] q_addr[$];
  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #4 clk = ~clk;

  per_meter #(.UNIT_LOG2(UNIT_LOG2), .ERR_W(ERR_W)) dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .pkt_valid(pkt_valid),
    .pkt_err(pkt_err), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .link_led_n(link_led_n)
  );

  // monitor: pops one expected read per cycle and compares it
  always @(negedge clk) begin
    if (q_addr.size() > 0) begin
      logic [2:0] a;
      logic [7:0] e;
      string      t;
      a = q_addr.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_checks++;
      if (rd_data !== e) begin
        n_fail++;
        $display("FAIL %s addr %0d: actual 0x%02h expected 0x%02h", t, a, rd_data, e);
      end
    end
  end

  task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    rd_addr = a;
    q_addr.push_back(a);
    q_exp.push_back(e);
    q_tag.push_back(t);
  endtask

  task automatic expect_led(input logic e, input string t);
    @(negedge clk);
    n_checks++;
    if (link_led_n !== e) begin
      n_fail++;
      $display("FAIL %s link_led_n: actual %0b expected %0b", t, link_led_n, e);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic write_with_pkt(input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = d;
    pkt_valid = 1'b1; pkt_err = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; pkt_valid = 1'b0; pkt_err = 1'b0;
  endtask

  task automatic send_pkts(input int n, input logic e);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      pkt_valid = 1'b1; pkt_err = e;
    end
    @(posedge clk); #1;
    pkt_valid = 1'b0; pkt_err = 1'b0;
  endtask

  task automatic err_only(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      pkt_valid = 1'b0; pkt_err = 1'b1;
    end
    @(posedge clk); #1;
    pkt_err = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; link_up = 1'b0; pkt_valid = 1'b0; pkt_err = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    expect_reg(3'd0, 8'h00, "R1");
    expect_reg(3'd1, 8'h00, "R1");
    expect_reg(3'd2, 8'h00, "R1");
    expect_reg(3'd3, 8'h00, "R1");
    expect_reg(3'd4, 8'h00, "R1");
    expect_led(1'b1, "R1");

    // R10: packets ignored while link is down
    reg_write(3'd0, 8'd1);
    send_pkts(4, 1'b1);
    expect_reg(3'd1, 8'h00, "R10");
    expect_reg(3'd4, 8'h00, "R10");
    link_up = 1'b1;
    repeat (2) @(posedge clk);
    expect_reg(3'd4, 8'h02, "R10");
    expect_led(1'b0, "R10");

    // R3 R4 R5 R9: restart window of 8 packets
    reg_write(3'd0, 8'd1);
    expect_reg(3'd0, 8'd1, "R3");
    send_pkts(4, 1'b1);
    err_only(3);
    send_pkts(3, 1'b0);
    expect_reg(3'd4, 8'h02, "R4");
    expect_reg(3'd1, 8'd4, "R5");
    send_pkts(1, 1'b1);
    expect_reg(3'd4, 8'h03, "R3");
    expect_reg(3'd1, 8'd5, "R5");
    // R8: ignored after done
    send_pkts(5, 1'b1);
    expect_reg(3'd1, 8'd5, "R8");
    expect_reg(3'd4, 8'h03, "R8");

    // R2: clear
    reg_write(3'd0, 8'd0);
    expect_reg(3'd0, 8'h00, "R2");
    expect_reg(3'd1, 8'h00, "R2");
    expect_reg(3'd4, 8'h02, "R2");

    // R9: restart mid-window with a new length
    reg_write(3'd0, 8'd2);
    send_pkts(5, 1'b1);
    expect_reg(3'd1, 8'd5, "R9");
    reg_write(3'd0, 8'd1);
    expect_reg(3'd0, 8'd1, "R9");
    expect_reg(3'd1, 8'd0, "R9");
    send_pkts(7, 1'b0);
    expect_reg(3'd4, 8'h02, "R9");
    send_pkts(1, 1'b0);
    expect_reg(3'd4, 8'h03, "R9");

    // R11: strobe colliding with a control write is dropped
    write_with_pkt(8'd1);
    expect_reg(3'd1, 8'd0, "R11");
    send_pkts(7, 1'b0);
    expect_reg(3'd4, 8'h02, "R11");
    send_pkts(1, 1'b0);
    expect_reg(3'd4, 8'h03, "R11");

    // R6 R7: byte split and saturation (count narrowed to 10 bits here)
    reg_write(3'd0, 8'd255);
    send_pkts(300, 1'b1);
    expect_reg(3'd1, 8'h2C, "R6");
    expect_reg(3'd2, 8'h01, "R6");
    expect_reg(3'd3, 8'h00, "R6");
    send_pkts(800, 1'b1);
    expect_reg(3'd1, 8'hFF, "R7");
    expect_reg(3'd2, 8'h03, "R7");
    expect_reg(3'd4, 8'h02, "R7");

    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule